// File: doc/BRIEF.md
# High-Memory MMIO Window Decoder

This block decides which downstream port of a host bridge owns a memory-mapped I/O access whose address lies above 4 GB. Software programs two 64-bit control registers through a small register port. The first register holds an enable bit and a coarse base that keeps address bits 39:32 only. The second holds a 6-bit power-of-two exponent that sets how large each port's share of the window is. The block clamps that exponent, aligns the base down to the share size, and treats the result as one contiguous window cut into equal slices, one slice per downstream port in ascending port order.

Each incoming transaction address is compared against the slices. If the window is enabled and the address falls inside one slice, the block raises a hit flag, reports that slice's port number, and passes the address through unchanged. Any write that lands in the control register neighbourhood (byte offsets 0x378 to 0x38F) causes the decode configuration to be rebuilt from the stored register values one clock later.

Top module: `hi_mmio_decoder`

## Requirements
- R1: After reset both control registers read as zero and no address is claimed.
- R2: A write to offset 0x378 stores bit 0 as the enable and bits 39:32 as the base; a read of 0x378 returns exactly those bits in the same positions and zero in every other bit.
- R3: A write to offset 0x388 stores bits 63:58 as the size exponent; a read of 0x388 returns that field in bits 63:58 and zero in every other bit.
- R4: The exponent used for decode is the stored exponent clamped to 29..33: values below 29 act as 29, values above 33 act as 33.
- R5: The base used for decode is the stored base aligned down to a multiple of 2^exponent.
- R6: With the window enabled, port n (0 to NPORTS-1) owns addresses from base + n*2^exponent through base + (n+1)*2^exponent - 1, and the reported port index equals (address - base) >> exponent.
- R7: Addresses below the aligned base, or at or above base + NPORTS*2^exponent, are not claimed.
- R8: When the stored enable bit is 0, no address is claimed, whatever the base and exponent hold.
- R9: On a hit the forwarded address equals the incoming address; on a miss the hit flag, the port index and the forwarded address are all zero.
- R10: A register write is visible on the read port right after the clock edge that takes it, while the decode keeps the previous configuration until the following clock edge, from which on it uses the new one.
- R11: Writes to offsets that name neither control register (for example 0x380 and 0x390) leave both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset for read and write |
| regWdata | input | 64 | Register write data |
| regRdata | output | 64 | Register read data for regAddr (combinational) |
| reqAddr | input | 64 | Transaction address to decode |
| hitValid | output | 1 | Address claimed by the window |
| hitPort | output | 3 | Target downstream port index |
| fwdAddr | output | 64 | Address forwarded to the target port |

## Verification
Register read data follows regAddr combinationally, so a readback is taken one time step after the address is set, and a written value is due on the read port in the cycle after the edge that captured the write. The decode outputs are combinational from a configuration register that is loaded one edge after the write edge, so a decode result for a new setting is due two edges after the write; the bench samples at the falling edge after the first edge to see the old configuration still in force and after the second edge to see the new one. All samples are taken at falling edges plus a settling step, away from the rising edge where state changes.

// File: rtl/himm_pkg.sv
package himm_pkg;

  localparam int DATA_W   = 64;
  localparam int REG_AW   = 12;

  // Register word offsets (byte addresses, low three bits ignored on access)
  localparam logic [REG_AW-1:0] OFS_BASE   = 12'h378;
  localparam logic [REG_AW-1:0] OFS_ROUTE  = 12'h388;
  // Window of offsets whose writes trigger a configuration rebuild
  localparam logic [REG_AW-1:0] OFS_RECALC_LO = 12'h378;
  localparam logic [REG_AW-1:0] OFS_RECALC_HI = 12'h38F;

  // Field placement
  localparam int BASE_LSB  = 32;
  localparam int BASE_MSB  = 39;
  localparam int BASE_W    = BASE_MSB - BASE_LSB + 1;
  localparam int EXP_LSB   = 58;
  localparam int EXP_W     = 6;
  localparam int EXP_MIN   = 29;
  localparam int EXP_MAX   = 33;

  typedef struct packed {
    logic wrBase;
    logic wrRoute;
    logic selBase;
    logic selRoute;
    logic rebuild;
  } ctrlStrb_t;

  typedef struct packed {
    logic              en;
    logic [EXP_W-1:0]  expo;
    logic [DATA_W-1:0] base;
  } winCfg_t;

endpackage

// File: rtl/himm_ctrl.sv
module himm_ctrl
  import himm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  output ctrlStrb_t         strb
);

  localparam int WORD_LSB = 3;

  logic isBase;
  logic isRoute;
  logic inRebuildZone;
  logic rebuildQ;

  always_comb begin
    isBase        = (regAddr[REG_AW-1:WORD_LSB] == OFS_BASE[REG_AW-1:WORD_LSB]);
    isRoute       = (regAddr[REG_AW-1:WORD_LSB] == OFS_ROUTE[REG_AW-1:WORD_LSB]);
    inRebuildZone = (regAddr >= OFS_RECALC_LO) && (regAddr <= OFS_RECALC_HI);
  end

  // The rebuild pulse trails the write by one edge so the datapath sees
  // the freshly stored register values when it derives the configuration.
  always_ff @(posedge clk) begin
    if (!rstN) rebuildQ <= 1'b0;
    else       rebuildQ <= regWe && inRebuildZone;
  end

  always_comb begin
    strb.wrBase   = regWe && isBase;
    strb.wrRoute  = regWe && isRoute;
    strb.selBase  = isBase;
    strb.selRoute = isRoute;
    strb.rebuild  = rebuildQ;
  end

endmodule

// File: rtl/himm_datapath.sv
module himm_datapath
  import himm_pkg::*;
#(
  parameter int NPORTS = 8,
  parameter int PORT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [DATA_W-1:0] reqAddr,
  output logic              hitValid,
  output logic [PORT_W-1:0] hitPort,
  output logic [DATA_W-1:0] fwdAddr,
  output winCfg_t           cfg
);

  logic              baseEnQ;
  logic [BASE_W-1:0] baseHiQ;
  logic [EXP_W-1:0]  routeExpQ;

  logic [EXP_W-1:0]  expClamped;
  logic [DATA_W-1:0] rawBase;
  logic [DATA_W-1:0] alignedBase;
  winCfg_t           cfgQ;

  // Register storage with sanitising on write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseEnQ   <= 1'b0;
      baseHiQ   <= '0;
      routeExpQ <= '0;
    end else begin
      if (strb.wrBase) begin
        baseEnQ <= regWdata[0];
        baseHiQ <= regWdata[BASE_MSB:BASE_LSB];
      end
      if (strb.wrRoute) begin
        routeExpQ <= regWdata[DATA_W-1:EXP_LSB];
      end
    end
  end

  // Read mux
  always_comb begin
    regRdata = '0;
    if (strb.selBase) begin
      regRdata[0]                 = baseEnQ;
      regRdata[BASE_MSB:BASE_LSB] = baseHiQ;
    end else if (strb.selRoute) begin
      regRdata[DATA_W-1:EXP_LSB]  = routeExpQ;
    end
  end

  // Clamp and align
  always_comb begin
    if (routeExpQ < EXP_W'(EXP_MIN))      expClamped = EXP_W'(EXP_MIN);
    else if (routeExpQ > EXP_W'(EXP_MAX)) expClamped = EXP_W'(EXP_MAX);
    else                                  expClamped = routeExpQ;
    rawBase                   = '0;
    rawBase[BASE_MSB:BASE_LSB] = baseHiQ;
    alignedBase = rawBase & ~((DATA_W'(1) << expClamped) - DATA_W'(1));
  end

  // Derived configuration, rebuilt on the trailing strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ.en   <= 1'b0;
      cfgQ.expo <= EXP_W'(EXP_MIN);
      cfgQ.base <= '0;
    end else if (strb.rebuild) begin
      cfgQ.en   <= baseEnQ;
      cfgQ.expo <= expClamped;
      cfgQ.base <= alignedBase;
    end
  end

  assign cfg = cfgQ;

  // Per-port slice compare
  logic [DATA_W-1:0] sliceSize;
  logic [NPORTS-1:0] portHit;

  assign sliceSize = DATA_W'(1) << cfgQ.expo;

  for (genvar p = 0; p < NPORTS; p++) begin : gSlice
    logic [DATA_W-1:0] sliceLo;
    logic [DATA_W-1:0] sliceHi;
    always_comb begin
      sliceLo    = cfgQ.base + (DATA_W'(p) << cfgQ.expo);
      sliceHi    = sliceLo + sliceSize;
      portHit[p] = cfgQ.en && (reqAddr >= sliceLo) && (reqAddr < sliceHi);
    end
  end

  // Encode the (at most one) hitting slice
  logic [PORT_W-1:0] portIdx;
  always_comb begin
    portIdx = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (portHit[p]) portIdx = portIdx | PORT_W'(p);
    end
  end

  always_comb begin
    hitValid = |portHit;
    hitPort  = hitValid ? portIdx : '0;
    fwdAddr  = hitValid ? reqAddr : '0;
  end

endmodule

// File: rtl/hi_mmio_decoder.sv
module hi_mmio_decoder
  import himm_pkg::*;
#(
  parameter int NPORTS = 8,
  localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [DATA_W-1:0] reqAddr,
  output logic              hitValid,
  output logic [PORT_W-1:0] hitPort,
  output logic [DATA_W-1:0] fwdAddr
);

  ctrlStrb_t strb;
  winCfg_t   cfg;

  himm_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWe   (regWe),
    .regAddr (regAddr),
    .strb    (strb)
  );

  himm_datapath #(
    .NPORTS (NPORTS),
    .PORT_W (PORT_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .reqAddr  (reqAddr),
    .hitValid (hitValid),
    .hitPort  (hitPort),
    .fwdAddr  (fwdAddr),
    .cfg      (cfg)
  );

endmodule

// File: rtl/himm_checker.sv
module himm_checker
  import himm_pkg::*;
#(
  parameter int NPORTS = 8,
  parameter int PORT_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [REG_AW-1:0] regAddr,
  input logic [DATA_W-1:0] regRdata,
  input logic [DATA_W-1:0] reqAddr,
  input logic              hitValid,
  input logic [PORT_W-1:0] hitPort,
  input logic [DATA_W-1:0] fwdAddr,
  input ctrlStrb_t         strb,
  input winCfg_t           cfg
);

  localparam logic [DATA_W-1:0] BASE_KEEP =
    (((DATA_W'(1) << BASE_W) - DATA_W'(1)) << BASE_LSB) | DATA_W'(1);

  // R9: misses drive zeros
  a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    !hitValid |-> (hitPort == '0) && (fwdAddr == '0));

  // R9: hits pass the address through
  a_r9_hit_forward: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> fwdAddr == reqAddr);

  // R2: base readback carries only kept bits
  a_r2_base_clean: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr[REG_AW-1:3] == OFS_BASE[REG_AW-1:3]) |-> (regRdata & ~BASE_KEEP) == '0);

  // R3: route readback carries only the exponent field
  a_r3_route_clean: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr[REG_AW-1:3] == OFS_ROUTE[REG_AW-1:3]) |-> regRdata[EXP_LSB-1:0] == '0);

  // R4: decode exponent within the clamp range
  a_r4_exp_range: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.expo >= EXP_W'(EXP_MIN)) && (cfg.expo <= EXP_W'(EXP_MAX)));

  // R5: decode base aligned to the slice size
  a_r5_base_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.base & ((DATA_W'(1) << cfg.expo) - DATA_W'(1))) == '0);

  // R8: disabled window claims nothing
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.en |-> !hitValid);

  // R6: reported port equals the scaled offset
  a_r6_port_index: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> hitPort == PORT_W'((reqAddr - cfg.base) >> cfg.expo));

  // R10: configuration only moves after a rebuild pulse
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rebuild |=> $stable(cfg));

endmodule

bind hi_mmio_decoder himm_checker #(
  .NPORTS (NPORTS),
  .PORT_W (PORT_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regRdata (regRdata),
  .reqAddr  (reqAddr),
  .hitValid (hitValid),
  .hitPort  (hitPort),
  .fwdAddr  (fwdAddr),
  .strb     (strb),
  .cfg      (cfg)
);

// File: tb/tb_hi_mmio_decoder.sv
`timescale 1ns/1ps
module tb_hi_mmio_decoder;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWe;
  logic [11:0] regAddr;
  logic [63:0] regWdata;
  logic [63:0] regRdata;
  logic [63:0] reqAddr;
  logic        hitValid;
  logic [2:0]  hitPort;
  logic [63:0] fwdAddr;

  int nChecks = 0;
  int nFails  = 0;
  bit doneRun = 1'b0;

  always #4 clk = ~clk;

  hi_mmio_decoder dut (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .reqAddr  (reqAddr),
    .hitValid (hitValid),
    .hitPort  (hitPort),
    .fwdAddr  (fwdAddr)
  );

  localparam logic [11:0] A_BASE  = 12'h378;
  localparam logic [11:0] A_ROUTE = 12'h388;

  task automatic checkVal(string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(logic [11:0] ofs, logic [63:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = ofs; regWdata = d;
    @(posedge clk);
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic regRead(logic [11:0] ofs, output logic [63:0] d);
    regAddr = ofs;
    #1;
    d = regRdata;
  endtask

  task automatic expectDecode(string req, logic [63:0] a, bit expHit, logic [2:0] expPort);
    reqAddr = a;
    #1;
    checkVal(req, $sformatf("hit @%h", a), 64'(hitValid), 64'(expHit));
    checkVal(req, $sformatf("port @%h", a), 64'(hitPort), expHit ? 64'(expPort) : 64'd0);
    checkVal("R9", $sformatf("fwd @%h", a), fwdAddr, expHit ? a : 64'd0);
  endtask

  function automatic logic [63:0] routeVal(int e);
    return {6'(e), 58'd0};
  endfunction

  task automatic testReset();
    logic [63:0] d;
    regRead(A_BASE, d);  checkVal("R1", "base after reset", d, 64'd0);
    regRead(A_ROUTE, d); checkVal("R1", "route after reset", d, 64'd0);
    expectDecode("R1", 64'h5_0000_0000, 1'b0, 3'd0);
    expectDecode("R1", 64'h0, 1'b0, 3'd0);
  endtask

  task automatic testSanitize();
    logic [63:0] d;
    regWrite(A_BASE, '1);
    regRead(A_BASE, d);  checkVal("R2", "base readback", d, 64'h0000_00FF_0000_0001);
    regWrite(A_ROUTE, '1);
    regRead(A_ROUTE, d); checkVal("R3", "route readback", d, 64'hFC00_0000_0000_0000);
    regWrite(A_ROUTE, 64'h0BFF_FFFF_FFFF_FFFF);
    regRead(A_ROUTE, d); checkVal("R3", "route partial", d, 64'h0800_0000_0000_0000);
  endtask

  task automatic testMapping();
    regWrite(A_ROUTE, routeVal(30));
    regWrite(A_BASE, 64'h5_0000_0001);
    settle();
    expectDecode("R6", 64'h5_0000_0000, 1'b1, 3'd0);
    expectDecode("R6", 64'h5_4000_0000, 1'b1, 3'd1);
    expectDecode("R6", 64'h5_BFFF_FFFF, 1'b1, 3'd2);
    expectDecode("R6", 64'h6_FFFF_FFFF, 1'b1, 3'd7);
    expectDecode("R7", 64'h7_0000_0000, 1'b0, 3'd0);
    expectDecode("R7", 64'h4_FFFF_FFFF, 1'b0, 3'd0);
  endtask

  task automatic testClamp();
    regWrite(A_ROUTE, routeVal(5));
    settle();
    expectDecode("R4", 64'h5_2000_0000, 1'b1, 3'd1);
    expectDecode("R4", 64'h5_FFFF_FFFF, 1'b1, 3'd7);
    expectDecode("R4", 64'h6_0000_0000, 1'b0, 3'd0);
    regWrite(A_ROUTE, routeVal(34));
    settle();
    expectDecode("R5", 64'h4_0000_0000, 1'b1, 3'd0);
    expectDecode("R4", 64'h6_0000_0000, 1'b1, 3'd1);
    expectDecode("R4", 64'h13_FFFF_FFFF, 1'b1, 3'd7);
    expectDecode("R7", 64'h14_0000_0000, 1'b0, 3'd0);
    expectDecode("R5", 64'h3_FFFF_FFFF, 1'b0, 3'd0);
  endtask

  task automatic testDisable();
    logic [63:0] d;
    regWrite(A_ROUTE, routeVal(30));
    regWrite(A_BASE, 64'h5_0000_0000);
    settle();
    regRead(A_BASE, d); checkVal("R2", "base no enable", d, 64'h5_0000_0000);
    expectDecode("R8", 64'h5_4000_0000, 1'b0, 3'd0);
    expectDecode("R8", 64'h5_0000_0000, 1'b0, 3'd0);
  endtask

  task automatic testTiming();
    logic [63:0] d;
    regWrite(A_BASE, 64'h5_0000_0001);
    settle();
    regWrite(A_BASE, 64'h9_0000_0001);
    regRead(A_BASE, d); checkVal("R10", "readback next cycle", d, 64'h9_0000_0001);
    expectDecode("R10", 64'h5_4000_0000, 1'b1, 3'd1);
    settle();
    expectDecode("R10", 64'h5_4000_0000, 1'b0, 3'd0);
    expectDecode("R10", 64'h9_4000_0000, 1'b1, 3'd1);
  endtask

  task automatic testIgnored();
    logic [63:0] d;
    regWrite(12'h380, '1);
    regWrite(12'h390, '1);
    settle();
    regRead(A_BASE, d);  checkVal("R11", "base untouched", d, 64'h9_0000_0001);
    regRead(A_ROUTE, d); checkVal("R11", "route untouched", d, routeVal(30));
    expectDecode("R11", 64'h9_4000_0000, 1'b1, 3'd1);
  endtask

  task automatic finishRun();
    if (!doneRun) begin
      doneRun = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    rstN = 1'b0; regWe = 1'b0; regAddr = '0; regWdata = '0; reqAddr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSanitize();
    testMapping();
    testClamp();
    testDisable();
    testTiming();
    testIgnored();
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule